// File: doc/BRIEF.md
# Deficit Round Robin Packet Scheduler

This block picks which of several packet queues may send next on a single output link. Each queue has its own byte budget, called its quantum. The block never sees packet data. For every queue it receives two inputs: a flag that says the queue holds a packet, and the byte length of the packet at the head of that queue.

The block keeps one deficit counter per queue. The counter records how many bytes the queue may still send, and any balance it does not spend carries over to the next round. Shares of the link are therefore set in bytes. Large packets and small packets get the same byte share for the same quantum.

When the block picks a packet, it raises a one-cycle dequeue grant. The grant carries the queue index and the packet length. The block then waits for a send-done pulse before it looks at the next head packet. Quanta are written through a small configuration port.

Top module: `drr_scheduler`

## Requirements
- R1: Reset clears every deficit counter and points the round pointer at queue 0. After reset no grant is issued while all queues are empty. The first grant after queues fill is served from the first non-empty queue at or after index 0.
- R2: Queues are visited in rising index order, wrapping from the last index to 0. A queue found empty when visited is skipped without any grant.
- R3: When a non-empty queue's turn begins, its quantum is added to its deficit counter exactly once. A head packet is granted only if the counter is greater than or equal to the packet length. The grant reports that queue's index on `grantIdx` and the head length on `grantLen`, and the length is then subtracted from the counter.
- R4: After each send the new head length is compared with the remaining balance. The same queue goes on sending, with no quantum added, for as long as the comparison holds and the queue is non-empty. A packet whose length equals the remaining balance is sent in the same turn.
- R5: When the head length exceeds the remaining balance, the turn moves to the next index. The unspent balance is kept for that queue's next turn.
- R6: A queue that is empty when its turn ends has its deficit counter cleared to 0. No balance from that turn adds to a later turn.
- R7: `grantValid` is high for exactly one cycle per packet. No further grant is issued until `sendDone` has been high for at least one cycle after the grant.
- R8: While every queue is empty, the block issues no grants and adds no quantum. Once a queue becomes non-empty, scanning resumes from the index after the last queue served.
- R9: A write with `cfgWe` high stores `cfgQuantum` as the quantum of queue `cfgIdx`. The new value is used from the start of that queue's next turn.
- R10: The deficit counter is as wide as the quantum width plus the length width, so adding a quantum never overflows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| qValid | input | NQ | Per-queue non-empty flags, bit i for queue i |
| qLen | input | NQ*LEN_W | Head packet lengths in bytes, queue i in bits [i*LEN_W +: LEN_W] |
| cfgWe | input | 1 | Quantum write strobe |
| cfgIdx | input | IDX_W | Queue index for the quantum write |
| cfgQuantum | input | QNT_W | Quantum value in bytes |
| sendDone | input | 1 | Pulse confirming that the last granted packet was transferred |
| grantValid | output | 1 | One-cycle dequeue grant |
| grantIdx | output | IDX_W | Queue index of the granted packet |
| grantLen | output | LEN_W | Length of the granted packet |

## Verification
A wrong deficit counter shows up at the ports within the next one or two turns of that queue. A counter that is too high lets an extra packet through in the same turn. A counter that is too low defers a packet that should have gone, which moves the grant to a different queue index. A wrong round pointer or a missed skip changes `grantIdx` on the very next grant. The bench compares the whole grant sequence of each phase with a byte-exact model of the round loop. A counter that is not cleared, or a quantum that is added twice, therefore appears as a wrong index or length at a known position in that sequence.

// File: rtl/drr_pkg.sv
package drr_pkg;

  typedef struct packed {
    logic addQ;     // add quantum of current queue to its counter
    logic send;     // grant head packet, subtract its length
    logic advance;  // move round pointer to next index
    logic clear;    // zero the current queue's counter
  } drrStrobe_t;

  typedef enum logic [1:0] {
    ST_SCAN  = 2'd0,
    ST_SERVE = 2'd1,
    ST_WAIT  = 2'd2
  } drrState_t;

endpackage

// File: rtl/drr_datapath.sv
module drr_datapath
  import drr_pkg::*;
#(
  parameter int NQ          = 4,
  parameter int LEN_W       = 11,
  parameter int QNT_W       = 12,
  parameter int DEF_QUANTUM = 1500,
  localparam int IDX_W      = (NQ > 1) ? $clog2(NQ) : 1,
  localparam int DC_W       = QNT_W + LEN_W
)(
  input  logic                  clk,
  input  logic                  rstN,
  input  drrStrobe_t            stb,
  input  logic [NQ-1:0]         qValid,
  input  logic [NQ*LEN_W-1:0]   qLen,
  input  logic                  cfgWe,
  input  logic [IDX_W-1:0]      cfgIdx,
  input  logic [QNT_W-1:0]      cfgQuantum,
  output logic                  curValid,
  output logic                  anyValid,
  output logic                  canSend,
  output logic                  grantValid,
  output logic [IDX_W-1:0]      grantIdx,
  output logic [LEN_W-1:0]      grantLen
);

  logic [IDX_W-1:0] ptr;
  logic [IDX_W-1:0] ptrNext;
  logic [QNT_W-1:0] quantum [NQ];
  logic [DC_W-1:0]  dc      [NQ];

  logic [LEN_W-1:0] curLen;
  logic [QNT_W-1:0] curQnt;
  logic [DC_W-1:0]  curDc;
  logic [DC_W-1:0]  lenExt;
  logic [DC_W:0]    addSum;

  // Current-queue selection
  always_comb begin
    curLen = '0;
    curQnt = '0;
    curDc  = '0;
    for (int i = 0; i < NQ; i++) begin
      if (ptr == IDX_W'(i)) begin
        curLen = qLen[i*LEN_W +: LEN_W];
        curQnt = quantum[i];
        curDc  = dc[i];
      end
    end
  end

  assign curValid = qValid[ptr];
  assign anyValid = |qValid;
  assign lenExt   = {{(DC_W-LEN_W){1'b0}}, curLen};
  assign canSend  = (curDc >= lenExt);
  assign addSum   = {1'b0, curDc} + {{(DC_W+1-QNT_W){1'b0}}, curQnt};
  assign ptrNext  = (ptr == IDX_W'(NQ-1)) ? '0 : ptr + 1'b1;

  // Round pointer
  always_ff @(posedge clk) begin
    if (!rstN)            ptr <= '0;
    else if (stb.advance) ptr <= ptrNext;
  end

  // Per-queue quantum registers and deficit counters
  for (genvar g = 0; g < NQ; g++) begin : g_queue
    logic sel;
    assign sel = (ptr == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rstN)
        quantum[g] <= QNT_W'(DEF_QUANTUM);
      else if (cfgWe && cfgIdx == IDX_W'(g))
        quantum[g] <= cfgQuantum;
    end

    always_ff @(posedge clk) begin
      if (!rstN)                 dc[g] <= '0;
      else if (sel && stb.addQ)  dc[g] <= addSum[DC_W-1:0];
      else if (sel && stb.send)  dc[g] <= curDc - lenExt;
      else if (sel && stb.clear) dc[g] <= '0;
    end
  end

  // Grant register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      grantValid <= 1'b0;
      grantIdx   <= '0;
      grantLen   <= '0;
    end else begin
      grantValid <= stb.send;
      if (stb.send) begin
        grantIdx <= ptr;
        grantLen <= curLen;
      end
    end
  end

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.addQ |-> !addSum[DC_W]);

  // R3
  send_covered_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.send |-> (curValid && canSend));

  // R7
  grant_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |=> !grantValid);

endmodule

// File: rtl/drr_control.sv
module drr_control
  import drr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       curValid,
  input  logic       anyValid,
  input  logic       canSend,
  input  logic       sendDone,
  output drrStrobe_t stb
);

  drrState_t state;
  drrState_t nextState;

  always_comb begin
    stb       = '0;
    nextState = state;
    unique case (state)
      ST_SCAN: begin
        if (curValid) begin
          stb.addQ  = 1'b1;
          nextState = ST_SERVE;
        end else if (anyValid) begin
          stb.clear   = 1'b1;
          stb.advance = 1'b1;
        end
      end
      ST_SERVE: begin
        if (!curValid) begin
          stb.clear   = 1'b1;
          stb.advance = 1'b1;
          nextState   = ST_SCAN;
        end else if (canSend) begin
          stb.send  = 1'b1;
          nextState = ST_WAIT;
        end else begin
          stb.advance = 1'b1;
          nextState   = ST_SCAN;
        end
      end
      ST_WAIT: begin
        if (sendDone) nextState = ST_SERVE;
      end
      default: nextState = ST_SCAN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_SCAN;
    else       state <= nextState;
  end

  // R7
  done_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && !sendDone) |=> !stb.send);

  // R8
  idle_no_add_chk: assert property (@(posedge clk) disable iff (!rstN)
    !anyValid |-> !stb.addQ);

  // R6
  empty_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SERVE && !curValid) |-> (stb.clear && stb.advance));

endmodule

// File: rtl/drr_scheduler.sv
module drr_scheduler
  import drr_pkg::*;
#(
  parameter int NQ          = 4,
  parameter int LEN_W       = 11,
  parameter int QNT_W       = 12,
  parameter int DEF_QUANTUM = 1500,
  localparam int IDX_W      = (NQ > 1) ? $clog2(NQ) : 1
)(
  input  logic                clk,
  input  logic                rstN,
  input  logic [NQ-1:0]       qValid,
  input  logic [NQ*LEN_W-1:0] qLen,
  input  logic                cfgWe,
  input  logic [IDX_W-1:0]    cfgIdx,
  input  logic [QNT_W-1:0]    cfgQuantum,
  input  logic                sendDone,
  output logic                grantValid,
  output logic [IDX_W-1:0]    grantIdx,
  output logic [LEN_W-1:0]    grantLen
);

  drrStrobe_t stb;
  logic       curValid;
  logic       anyValid;
  logic       canSend;

  drr_control i_control (
    .clk      (clk),
    .rstN     (rstN),
    .curValid (curValid),
    .anyValid (anyValid),
    .canSend  (canSend),
    .sendDone (sendDone),
    .stb      (stb)
  );

  drr_datapath #(
    .NQ          (NQ),
    .LEN_W       (LEN_W),
    .QNT_W       (QNT_W),
    .DEF_QUANTUM (DEF_QUANTUM)
  ) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .qValid     (qValid),
    .qLen       (qLen),
    .cfgWe      (cfgWe),
    .cfgIdx     (cfgIdx),
    .cfgQuantum (cfgQuantum),
    .curValid   (curValid),
    .anyValid   (anyValid),
    .canSend    (canSend),
    .grantValid (grantValid),
    .grantIdx   (grantIdx),
    .grantLen   (grantLen)
  );

endmodule

// File: tb/test_drr_scheduler.sv
module test_drr_scheduler;

  localparam int NQ     = 4;
  localparam int LEN_W  = 11;
  localparam int QNT_W  = 12;
  localparam int IDX_W  = 2;
  localparam int DEPTH  = 16;
  localparam int MAXLEN = 1500;
  localparam int DEFQ   = 1500;

  logic                clk = 1'b0;
  logic                rstN;
  logic [NQ-1:0]       qValid;
  logic [NQ*LEN_W-1:0] qLen;
  logic                cfgWe;
  logic [IDX_W-1:0]    cfgIdx;
  logic [QNT_W-1:0]    cfgQuantum;
  logic                sendDone;
  logic                grantValid;
  logic [IDX_W-1:0]    grantIdx;
  logic [LEN_W-1:0]    grantLen;

  int checks = 0;
  int fails  = 0;

  int qData [NQ][DEPTH];
  int qHead [NQ];
  int qCnt  [NQ];
  int modelQnt [NQ];
  int modelDc  [NQ];
  int modelPtr;
  int expIdx [NQ*DEPTH];
  int expLen [NQ*DEPTH];
  int expN;

  always #4 clk = ~clk;

  drr_scheduler #(
    .NQ(NQ), .LEN_W(LEN_W), .QNT_W(QNT_W), .DEF_QUANTUM(DEFQ)
  ) i_drr_scheduler (
    .clk(clk), .rstN(rstN), .qValid(qValid), .qLen(qLen),
    .cfgWe(cfgWe), .cfgIdx(cfgIdx), .cfgQuantum(cfgQuantum),
    .sendDone(sendDone), .grantValid(grantValid),
    .grantIdx(grantIdx), .grantLen(grantLen)
  );

  always_comb begin
    for (int i = 0; i < NQ; i++) begin
      qValid[i] = (qCnt[i] > 0);
      qLen[i*LEN_W +: LEN_W] = (qCnt[i] > 0) ?
        LEN_W'(qData[i][qHead[i] % DEPTH]) : '0;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic writeQuantum(input int idx, input int val);
    @(negedge clk);
    cfgWe      = 1'b1;
    cfgIdx     = IDX_W'(idx);
    cfgQuantum = QNT_W'(val);
    @(negedge clk);
    cfgWe = 1'b0;
    modelQnt[idx] = val;
  endtask

  // Byte-exact round loop producing the expected grant sequence
  task automatic buildModel();
    int cnt [NQ];
    int hd  [NQ];
    int total;
    total = 0;
    for (int i = 0; i < NQ; i++) begin
      cnt[i] = qCnt[i];
      hd[i]  = qHead[i];
      total += cnt[i];
    end
    expN = 0;
    while (total > 0) begin
      int i;
      i = modelPtr;
      if (cnt[i] > 0) begin
        modelDc[i] += modelQnt[i];
        while (cnt[i] > 0 && modelDc[i] >= qData[i][hd[i]]) begin
          modelDc[i] -= qData[i][hd[i]];
          expIdx[expN] = i;
          expLen[expN] = qData[i][hd[i]];
          expN++;
          hd[i]++;
          cnt[i]--;
          total--;
        end
      end
      if (cnt[i] == 0) modelDc[i] = 0;
      modelPtr = (i + 1) % NQ;
    end
  endtask

  task automatic runPhase(input string tag);
    buildModel();
    for (int k = 0; k < expN; k++) begin
      int t;
      int d;
      t = 0;
      while (!grantValid && t < 300) begin
        @(negedge clk);
        t++;
      end
      if (!grantValid) begin
        check(1'b0, {"R7 grant timeout ", tag}, k, expN);
        return;
      end
      check(int'(grantIdx) == expIdx[k], {"R2 grant index ", tag}, int'(grantIdx), expIdx[k]);
      check(int'(grantLen) == expLen[k], {"R3 grant length ", tag}, int'(grantLen), expLen[k]);
      qHead[grantIdx]++;
      qCnt[grantIdx]--;
      d = $urandom % 4;
      for (int w = 0; w < d; w++) begin
        @(negedge clk);
        check(!grantValid, "R7 no grant before done", int'(grantValid), 0);
      end
      sendDone = 1'b1;
      @(negedge clk);
      sendDone = 1'b0;
      check(!grantValid, "R7 single-cycle grant", int'(grantValid), 0);
    end
    for (int w = 0; w < 20; w++) begin
      @(negedge clk);
      check(!grantValid, {"R8 idle no grant ", tag}, int'(grantValid), 0);
    end
  endtask

  task automatic loadQueue(input int idx, input int n, input int l0, input int l1);
    qHead[idx] = 0;
    qData[idx][0] = l0;
    qData[idx][1] = l1;
    qCnt[idx] = n;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rstN = 1'b0; sendDone = 1'b0; cfgWe = 1'b0; cfgIdx = '0; cfgQuantum = '0;
    for (int i = 0; i < NQ; i++) begin
      qHead[i] = 0; qCnt[i] = 0; modelQnt[i] = DEFQ; modelDc[i] = 0;
      for (int j = 0; j < DEPTH; j++) qData[i][j] = 1;
    end
    modelPtr = 0;
    repeat (5) @(negedge clk);
    check(!grantValid, "R1 reset grant low", int'(grantValid), 0);
    rstN = 1'b1;
    for (int w = 0; w < 10; w++) begin
      @(negedge clk);
      check(!grantValid, "R8 idle after reset", int'(grantValid), 0);
    end

    // Directed: equal-balance send (R4), carry-over (R5), skip of queue 2, first from queue 0 (R1)
    for (int i = 0; i < NQ; i++) writeQuantum(i, 100);
    @(negedge clk);
    loadQueue(0, 2, 60, 40);
    loadQueue(1, 2, 60, 41);
    loadQueue(3, 1, 30, 0);
    runPhase("R1 R4 R5");

    // Directed: queue 3 left balance 70 must be cleared (R6); raised quantum (R9); resume at 2 (R8)
    writeQuantum(2, 300);
    @(negedge clk);
    loadQueue(0, 1, 100, 0);
    loadQueue(2, 2, 150, 150);
    loadQueue(3, 2, 100, 50);
    runPhase("R6 R8 R9");

    // Constrained random phases
    for (int p = 0; p < 40; p++) begin
      for (int i = 0; i < NQ; i++)
        if ($urandom % 3 == 0) writeQuantum(i, MAXLEN + int'($urandom % (4096 - MAXLEN)));
      @(negedge clk);
      for (int i = 0; i < NQ; i++) begin
        int n;
        n = $urandom % 9;
        qHead[i] = 0;
        for (int j = 0; j < n; j++) qData[i][j] = 1 + int'($urandom % MAXLEN);
        qCnt[i] = n;
      end
      runPhase("random R2 R3 R9");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog R7: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule